// File: doc/BRIEF.md
# Digital Slope-Adaptive Delta Voice Codec

This block is a full-duplex continuously variable slope delta modulation codec that works only on digital samples. The encoder direction takes one signed PCM sample on each encoder strobe and produces one bit. The bit is 1 when the sample is at least the running estimate. The decoder direction takes one received bit on each decoder strobe and rebuilds the PCM estimate from it. The two directions share no state, and each is driven by its own strobe, so they can run at unrelated bit rates. The expected span is 8 to 128 kbit/s, with the strobes derived elsewhere from the system clock.

Each direction keeps three pieces of state. A four-bit run history records the most recent bits. A step size grows while the history shows a run of equal bits and otherwise leaks back toward a floor. A principal integrator moves by the step size and leaks toward zero. Both directions use the same update rule, so a decoder fed the encoder's bit stream tracks the encoder's estimate exactly. Per-direction force-idle inputs substitute a perfect alternating pattern. A powersave input freezes the whole codec. A data-enable input together with powersave decides whether the encoder bit is presented, which the output-valid flag reports.

Top module: `cvsd_codec`

## Requirements
- R1: A synchronous reset (`rst` high) clears both estimates to 0 and sets both step sizes to STEP_MIN (16). It loads both run histories with the oldest-to-newest pattern 0,1,0,1, so the newest bit is 1. It also sets `encBit` to 1.
- R2: On an encoder update the new bit is 1 when `$signed(encSample)` is greater than or equal to the encoder estimate held before that update, and 0 otherwise. `encBit` shows the bit one clock after the strobe.
- R3: On each update the new bit is shifted into the history. When `algo3Bit` is 1 and the newest 3 bits are all equal, or when `algo3Bit` is 0 and the newest 4 bits are all equal, the step becomes min(step+64, 4096). Otherwise the step becomes max(step - (step>>4), 16).
- R4: After the step update, the estimate becomes t - (t>>>5), where t = est + step for bit 1 and t = est - step for bit 0. The result is saturated to the range -32768..32767.
- R5: While `encForceIdleN` is 0, every encoder update emits the inverse of the previous encoder bit. The output therefore alternates 0,1,0,1 regardless of `encSample`.
- R6: While `decForceIdleN` is 0, every decoder update uses the inverse of the decoder's previous bit in place of `decBit`. `decSample` then settles near zero.
- R7: `encBitValid` is 1 exactly when `dataEnable` is 1 and `powerSaveN` is 1. It models the high-impedance state of the bit output.
- R8: While `powerSaveN` is 0, strobes are ignored: no estimate, step, history or `encBit` changes.
- R9: The two directions update independently, each on its own strobe. A decoder given the encoder's bits from the same reset state reproduces the encoder's estimate sequence exactly.
- R10: `decSample` shows the decoder estimate one clock after the decoder strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| powerSaveN | input | 1 | 0 freezes the codec |
| algo3Bit | input | 1 | 1 selects 3-bit run detection, 0 selects 4-bit |
| encEn | input | 1 | Encoder data strobe |
| encSample | input | 16 | Signed PCM sample to encode |
| encForceIdleN | input | 1 | 0 forces an alternating encoder output |
| dataEnable | input | 1 | Presents the encoder bit when 1 |
| encBit | output | 1 | Encoded bit |
| encBitValid | output | 1 | Encoder bit is driven |
| decEn | input | 1 | Decoder data strobe |
| decBit | input | 1 | Received bit |
| decForceIdleN | input | 1 | 0 substitutes an alternating pattern for received bits |
| decSample | output | 16 | Signed reconstructed PCM sample |

## Verification
The bench drives a constant full-scale input until the step reaches its ceiling and the estimate clips. A design with no saturation, or with the clamp applied before the leak, would wrap or stop short of 32767 and -32768. It switches between 3-bit and 4-bit run detection on runs of exactly three equal bits, which separates the two modes: a design with the mode swapped grows the step on the wrong run. It holds powersave with strobes active, where a design that ignored it would change `encBit` or `decSample`. It runs a loopback from a fresh reset, where any mismatch between the encoder and decoder update rules shows up as a diverging decoder estimate.

// File: rtl/cvsd_pkg.sv
package cvsd_pkg;
  // Strobes the control sends to one direction's slope datapath
  typedef struct packed {
    logic upd;     // advance state this cycle
    logic bitVal;  // bit applied on this update
    logic use3;    // 3-bit run detection when set
  } slopeCtl_t;
endpackage

// File: rtl/cvsd_slope.sv
module cvsd_slope
  import cvsd_pkg::*;
#(
  parameter int W          = 16,
  parameter int STEP_MIN   = 16,
  parameter int STEP_MAX   = 4096,
  parameter int STEP_INC   = 64,
  parameter int SYL_SHIFT  = 4,
  parameter int LEAK_SHIFT = 5,
  parameter int HIST_W     = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  slopeCtl_t           ctl,
  output logic signed [W-1:0] est,
  output logic                lastBit
);
  localparam int AW = W + 3;
  localparam logic [W-1:0] SMIN = W'(STEP_MIN);
  localparam logic [W-1:0] SMAX = W'(STEP_MAX);
  localparam logic [W:0]   SINC = (W+1)'(STEP_INC);
  localparam logic signed [AW-1:0] HI = AW'((1 << (W-1)) - 1);
  localparam logic signed [AW-1:0] LO = -AW'(1 << (W-1));
  localparam logic [HIST_W-1:0] HIST_RST = HIST_W'(4'b0101);

  logic [HIST_W-1:0] hist, histNext;
  logic [W-1:0]      step, stepNext, stepDecay;
  logic [W:0]        stepGrow;
  logic              coin3, coin4, coin;
  logic signed [AW-1:0] estX, stepX, sum, leaked;
  logic signed [W-1:0]  estNext;

  // run detection on the history including the incoming bit
  always_comb begin
    histNext = {hist[HIST_W-2:0], ctl.bitVal};
    coin3 = (histNext[2:0] == 3'b000) || (histNext[2:0] == 3'b111);
    coin4 = (histNext[3:0] == 4'b0000) || (histNext[3:0] == 4'b1111);
    coin  = ctl.use3 ? coin3 : coin4;
  end

  // syllabic integrator: grow on a run, leak otherwise
  always_comb begin
    stepGrow  = {1'b0, step} + SINC;
    stepDecay = step - (step >> SYL_SHIFT);
    if (coin)
      stepNext = (stepGrow > {1'b0, SMAX}) ? SMAX : stepGrow[W-1:0];
    else
      stepNext = (stepDecay < SMIN) ? SMIN : stepDecay;
  end

  // principal integrator: move by step, leak, saturate
  always_comb begin
    estX   = {{3{est[W-1]}}, est};
    stepX  = $signed({3'b000, stepNext});
    sum    = ctl.bitVal ? (estX + stepX) : (estX - stepX);
    leaked = sum - (sum >>> LEAK_SHIFT);
    if (leaked > HI)      estNext = HI[W-1:0];
    else if (leaked < LO) estNext = LO[W-1:0];
    else                  estNext = leaked[W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hist <= HIST_RST;
      step <= SMIN;
      est  <= '0;
    end else if (ctl.upd) begin
      hist <= histNext;
      step <= stepNext;
      est  <= estNext;
    end
  end

  assign lastBit = hist[0];

  p_step_bounds_r3: assert property (@(posedge clk) disable iff (rst)
    (step >= SMIN) && (step <= SMAX));
  p_run_grows_r3: assert property (@(posedge clk) disable iff (rst)
    (ctl.upd && coin) |=> (step >= $past(step)));
  p_freeze_r8: assert property (@(posedge clk) disable iff (rst)
    !ctl.upd |=> ($stable(est) && $stable(step) && $stable(hist)));
  p_bit_recorded_r9: assert property (@(posedge clk) disable iff (rst)
    ctl.upd |=> (lastBit == $past(ctl.bitVal)));
endmodule

// File: rtl/cvsd_ctrl.sv
module cvsd_ctrl
  import cvsd_pkg::*;
#(
  parameter int W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                powerSaveN,
  input  logic                algo3Bit,
  input  logic                encEn,
  input  logic                encForceIdleN,
  input  logic signed [W-1:0] encSample,
  input  logic signed [W-1:0] encEst,
  input  logic                encLast,
  input  logic                decEn,
  input  logic                decForceIdleN,
  input  logic                decBitIn,
  input  logic                decLast,
  output slopeCtl_t           encCtl,
  output slopeCtl_t           decCtl,
  output logic                encBit
);
  logic encNewBit;

  always_comb begin
    encNewBit = !encForceIdleN ? ~encLast : (encSample >= encEst);
    encCtl.upd    = encEn && powerSaveN;
    encCtl.bitVal = encNewBit;
    encCtl.use3   = algo3Bit;
    decCtl.upd    = decEn && powerSaveN;
    decCtl.bitVal = !decForceIdleN ? ~decLast : decBitIn;
    decCtl.use3   = algo3Bit;
  end

  always_ff @(posedge clk) begin
    if (rst)             encBit <= 1'b1;
    else if (encCtl.upd) encBit <= encNewBit;
  end

  p_idle_alternates_r5: assert property (@(posedge clk) disable iff (rst)
    (encCtl.upd && !encForceIdleN) |=> (encBit != $past(encBit)));
  p_hold_in_powersave_r8: assert property (@(posedge clk) disable iff (rst)
    !powerSaveN |=> $stable(encBit));
  p_dec_idle_flip_r6: assert property (@(posedge clk) disable iff (rst)
    (decCtl.upd && !decForceIdleN) |-> (decCtl.bitVal != decLast));
endmodule

// File: rtl/cvsd_codec.sv
module cvsd_codec
  import cvsd_pkg::*;
#(
  parameter int W          = 16,
  parameter int STEP_MIN   = 16,
  parameter int STEP_MAX   = 4096,
  parameter int STEP_INC   = 64,
  parameter int SYL_SHIFT  = 4,
  parameter int LEAK_SHIFT = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         powerSaveN,
  input  logic         algo3Bit,
  input  logic         encEn,
  input  logic [W-1:0] encSample,
  input  logic         encForceIdleN,
  input  logic         dataEnable,
  output logic         encBit,
  output logic         encBitValid,
  input  logic         decEn,
  input  logic         decBit,
  input  logic         decForceIdleN,
  output logic [W-1:0] decSample
);
  slopeCtl_t encCtl, decCtl;
  logic signed [W-1:0] encEst, decEst;
  logic encLast, decLast;

  cvsd_ctrl #(.W(W)) u_ctrl (
    .clk(clk), .rst(rst), .powerSaveN(powerSaveN), .algo3Bit(algo3Bit),
    .encEn(encEn), .encForceIdleN(encForceIdleN), .encSample($signed(encSample)),
    .encEst(encEst), .encLast(encLast),
    .decEn(decEn), .decForceIdleN(decForceIdleN), .decBitIn(decBit),
    .decLast(decLast), .encCtl(encCtl), .decCtl(decCtl), .encBit(encBit)
  );

  cvsd_slope #(.W(W), .STEP_MIN(STEP_MIN), .STEP_MAX(STEP_MAX), .STEP_INC(STEP_INC),
               .SYL_SHIFT(SYL_SHIFT), .LEAK_SHIFT(LEAK_SHIFT)) u_encPath (
    .clk(clk), .rst(rst), .ctl(encCtl), .est(encEst), .lastBit(encLast)
  );

  cvsd_slope #(.W(W), .STEP_MIN(STEP_MIN), .STEP_MAX(STEP_MAX), .STEP_INC(STEP_INC),
               .SYL_SHIFT(SYL_SHIFT), .LEAK_SHIFT(LEAK_SHIFT)) u_decPath (
    .clk(clk), .rst(rst), .ctl(decCtl), .est(decEst), .lastBit(decLast)
  );

  assign decSample   = decEst;
  assign encBitValid = dataEnable && powerSaveN;

  p_valid_gated_r7: assert property (@(posedge clk) disable iff (rst)
    !powerSaveN |-> !encBitValid);
  p_dec_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !decCtl.upd |=> $stable(decSample));
endmodule

// File: tb/tb_cvsd_codec.sv
`timescale 1ns/100ps
module tb_cvsd_codec;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic powerSaveN = 1'b1, algo3Bit = 1'b0, encEn = 1'b0, encForceIdleN = 1'b1;
  logic dataEnable = 1'b1, decEn = 1'b0, decBit = 1'b0, decForceIdleN = 1'b1;
  logic [15:0] encSample = '0;
  logic encBit, encBitValid;
  logic [15:0] decSample;

  always #2 clk = ~clk;

  cvsd_codec dut (
    .clk(clk), .rst(rst), .powerSaveN(powerSaveN), .algo3Bit(algo3Bit),
    .encEn(encEn), .encSample(encSample), .encForceIdleN(encForceIdleN),
    .dataEnable(dataEnable), .encBit(encBit), .encBitValid(encBitValid),
    .decEn(decEn), .decBit(decBit), .decForceIdleN(decForceIdleN),
    .decSample(decSample)
  );

  int checks = 0, errors = 0;
  bit finished = 0;

  // reference model, index 0 = encoder, 1 = decoder
  int mEst[2], mStep[2], mHist[2];
  int mEncBit;

  // scoreboard queues
  logic qEb[$];
  logic qV[$];
  logic [15:0] qDs[$];
  string qTag[$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic void mReset();
    for (int d = 0; d < 2; d++) begin
      mEst[d] = 0; mStep[d] = 16; mHist[d] = 5;
    end
    mEncBit = 1;
  endfunction

  // R3 / R4 update rule computed from the requirement text
  function automatic void mUpdate(input int d, input int b, input bit use3);
    int h, s, t, lk;
    bit coin;
    h = ((mHist[d] << 1) | b) & 15;
    coin = use3 ? (((h & 7) == 0) || ((h & 7) == 7)) : ((h == 0) || (h == 15));
    s = mStep[d];
    if (coin) s = (s + 64 > 4096) ? 4096 : s + 64;
    else      s = (s - (s >> 4) < 16) ? 16 : s - (s >> 4);
    t = b ? mEst[d] + s : mEst[d] - s;
    lk = t - (t >>> 5);
    if (lk > 32767) lk = 32767;
    if (lk < -32768) lk = -32768;
    mHist[d] = h; mStep[d] = s; mEst[d] = lk;
  endfunction

  task automatic drive(input bit ee, input int sample, input bit eIdleN,
                       input bit de, input bit dBit, input bit dIdleN,
                       input bit ps, input bit dEn, input bit a3, input string tag);
    int eb, db;
    @(negedge clk);
    encEn = ee; encSample = 16'(sample); encForceIdleN = eIdleN;
    decEn = de; decBit = dBit; decForceIdleN = dIdleN;
    powerSaveN = ps; dataEnable = dEn; algo3Bit = a3;
    if (ee && ps) begin
      eb = !eIdleN ? ((mHist[0] & 1) ^ 1) : ((sample >= mEst[0]) ? 1 : 0);
      mUpdate(0, eb, a3);
      mEncBit = eb;
    end
    if (de && ps) begin
      db = !dIdleN ? ((mHist[1] & 1) ^ 1) : int'(dBit);
      mUpdate(1, db, a3);
    end
    @(posedge clk);
    #0.5;
    qEb.push_back(mEncBit[0]);
    qDs.push_back(16'(mEst[1]));
    qV.push_back(dEn && ps);
    qTag.push_back(tag);
  endtask

  // monitor: compare outputs against expected items one cycle after the strobe
  always @(posedge clk) begin
    #1;
    while (qTag.size() > 0) begin
      logic eb, v;
      logic [15:0] ds;
      string tg;
      eb = qEb.pop_front(); ds = qDs.pop_front(); v = qV.pop_front(); tg = qTag.pop_front();
      chk(encBit === eb, {tg, " encBit"}, int'(encBit), int'(eb));
      chk(decSample === ds, {tg, " decSample (R10)"}, int'($signed(decSample)), int'($signed(ds)));
      chk(encBitValid === v, {tg, " encBitValid (R7)"}, int'(encBitValid), int'(v));
    end
  end

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; encEn = 0; decEn = 0;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    mReset();
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    finish();
  end

  initial begin
    int lbEst[64];
    logic lbBit[64];
    logic prevBit;
    int v;
    mReset();
    doReset();
    #0.5;
    // R1 reset state
    chk(encBit === 1'b1, "R1 encBit after reset", int'(encBit), 1);
    chk(decSample === 16'd0, "R1 decSample after reset", int'(decSample), 0);

    // R2, R4, R9: sine-like input, 4-bit mode; independent decoder bit stream
    for (int i = 0; i < 200; i++) begin
      v = int'(12000.0 * $sin(i * 0.11));
      drive(1, v, 1, (i % 3) != 0, ((i * 7) % 5) < 2, 1, 1, 1, 0, "R2 R4 R9 sine 4-bit");
    end
    // R4 saturation both directions
    for (int i = 0; i < 80; i++)
      drive(1, 32767, 1, 1, 0, 1, 1, 1, 0, "R4 saturate");
    chk(encBit === 1'b1, "R4 full-scale bit", int'(encBit), 1);
    chk(decSample === 16'h8000, "R4 negative clip", int'($signed(decSample)), -32768);
    // R3 3-bit mode with runs of exactly three equal bits on the decoder
    for (int i = 0; i < 120; i++)
      drive(1, (i % 12 < 6) ? 9000 : -9000, 1, 1, ((i / 3) % 2) == 1, 1, 1, 1, 1, "R3 3-bit mode");
    for (int i = 0; i < 120; i++)
      drive(1, (i % 12 < 6) ? 9000 : -9000, 1, 1, ((i / 3) % 2) == 1, 1, 1, 1, 0, "R3 4-bit mode");

    // R5 encoder force idle with a large input
    prevBit = encBit;
    for (int i = 0; i < 20; i++) begin
      drive(1, 30000, 0, 0, 0, 1, 1, 1, 0, "R5 encoder idle");
      #0.6;
      chk(encBit !== prevBit, "R5 alternation", int'(encBit), int'(~prevBit));
      prevBit = encBit;
    end

    // R7 data enable low; encoder still runs
    for (int i = 0; i < 10; i++)
      drive(1, (i % 2) ? 500 : -500, 1, 1, i[0], 1, 1, 0, 0, "R7 data disabled");
    // R8 powersave with strobes active
    for (int i = 0; i < 15; i++)
      drive(1, 20000, 1, 1, 1, 1, 0, 1, 0, "R8 powersave");

    // R6 decoder force idle from a large estimate
    for (int i = 0; i < 30; i++)
      drive(0, 0, 1, 1, 1, 1, 1, 1, 0, "R6 push decoder high");
    for (int i = 0; i < 400; i++)
      drive(0, 0, 1, 1, 1, 0, 1, 1, 0, "R6 decoder idle");
    #0.6;
    v = int'($signed(decSample));
    chk((v <= 64) && (v >= -64), "R6 settle near zero", v, 0);

    // R9 loopback from a fresh reset
    doReset();
    for (int i = 0; i < 64; i++) begin
      drive(1, int'(8000.0 * $sin(i * 0.3)), 1, 0, 0, 1, 1, 1, 0, "R9 loopback enc");
      #0.6;
      lbBit[i] = encBit;
      lbEst[i] = mEst[0];
    end
    for (int i = 0; i < 64; i++) begin
      drive(0, 0, 1, 1, lbBit[i], 1, 1, 1, 0, "R9 loopback dec");
      #0.6;
      if (i % 8 == 7)
        chk(int'($signed(decSample)) == lbEst[i], "R9 loopback match",
            int'($signed(decSample)), lbEst[i]);
    end

    @(negedge clk);
    @(negedge clk);
    finish();
  end
endmodule